// File: doc/BRIEF.md
# Bytecode Instruction Length Decoder

This block sits between an instruction prefetch unit and a micro-operation queueing stage. It takes an unframed stream of bytecode bytes and splits it into instructions of varying length. The first byte of each instruction is an opcode. A per-opcode table gives the total length of the instruction and the index of its first micro-operation. The block sends that index downstream, and it reports every operand byte together with its position inside its instruction. A prefix byte (default `8'hC4`) does not decode by itself. It arms a wide mode that selects a separate table entry for the next opcode. A wide instruction carries twice the operand bytes of its normal form.

Both byte input and index output use a valid/ready handshake. The index output is a single register slot. While a held index is not taken, the input stalls. When `out_ready` is high, one byte is accepted every cycle. Operand bytes and illegal-opcode events are one-cycle pulses that appear one cycle after the byte is accepted. An opcode with no table entry is consumed as a 1-byte instruction.

Top module: `bytecode_len_decoder`

## Requirements
- R1: After synchronous reset, `out_valid`, `opnd_valid` and `illegal` are low, and the first byte accepted is decoded as an opcode, even if reset came in the middle of an instruction.
- R2: In normal mode the instruction length follows opcode bits [7:6]: `00` gives 1 byte, `01` gives 2 bytes, `10` gives 3 bytes. The bytes after the opcode, up to that length, are operands, and the byte after them is the next opcode.
- R3: When a normal opcode with a valid entry is accepted, `out_valid` is high in the next cycle with `out_uidx = {1'b0, 1'b0, opcode}`.
- R4: The prefix byte, seen where an opcode is expected in normal mode, emits no index and arms wide mode. A following opcode with bits [7:6] = `01` decodes as a 3-byte instruction with `out_uidx = {1'b1, 1'b0, opcode}`. Wide mode is cleared by the next opcode.
- R5: In wide mode, any opcode whose bits [7:6] are not `01` has no entry, and this includes a second prefix byte. Such an opcode is treated as illegal and clears wide mode.
- R6: An opcode with no entry raises `illegal` for exactly the cycle after it is accepted. It emits no index and no operand, and it is consumed as a 1-byte instruction. In normal mode these are the opcodes with bits [7:6] = `11`, except the prefix.
- R7: Each operand byte appears on `opnd_data` with `opnd_valid` high for one cycle, in the cycle after it is accepted. `opnd_pos` gives its position within the instruction: 1 for the byte right after the opcode, counting up.
- R8: While `out_valid` is high and `out_ready` is low, `in_ready` is low and `out_uidx` holds its value. Whenever `out_valid` is low or `out_ready` is high, `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Byte offered by prefetch unit |
| in_data | input | 8 | Offered byte |
| in_ready | output | 1 | Block can accept the byte |
| out_valid | output | 1 | Micro-operation index available |
| out_uidx | output | 10 | Micro-operation index {wide, 0, opcode} |
| out_ready | input | 1 | Queueing stage takes the index |
| opnd_valid | output | 1 | Operand byte pulse |
| opnd_data | output | 8 | Operand byte value |
| opnd_pos | output | 2 | Operand position within its instruction |
| illegal | output | 1 | Illegal-opcode pulse |

## Verification
The assertions check the handshake on every cycle: a held index stays stable, input stalls under backpressure, and every operand or illegal pulse follows an accepted byte. They also check that operand positions stay in range, that a wide index always carries a two-byte-operand opcode, and that the outputs are clear after reset. Only the bench scenarios can show that bytes are classed correctly as opcode or operand. The same goes for the exact index values, the prefix folding, and how illegal, double-prefix and mid-instruction-reset streams recover. The bench shows these by tracking the stream byte by byte against a reference model of the length rules.

// File: rtl/bld_pkg.sv
package bld_pkg;

    localparam int BYTE_W = 8;
    localparam int IDX_W  = BYTE_W + 2;
    localparam int LEN_W  = 2;
    localparam int POS_W  = 2;

    typedef enum logic [1:0] {
        CLS_SHORT = 2'b00,
        CLS_MID   = 2'b01,
        CLS_LONG  = 2'b10,
        CLS_NONE  = 2'b11
    } opc_class_t;

    typedef struct packed {
        logic              wide;
        logic [BYTE_W-1:0] opc;
    } tbl_addr_t;

    typedef struct packed {
        logic [LEN_W-1:0] len;
        logic [IDX_W-1:0] uidx;
    } tbl_entry_t;

    typedef struct packed {
        logic              vld;
        logic [BYTE_W-1:0] data;
        logic [POS_W-1:0]  pos;
    } opnd_t;

    function automatic opc_class_t classify(input logic [BYTE_W-1:0] opc);
        return opc_class_t'(opc[BYTE_W-1 -: 2]);
    endfunction

    // Entry for one table row; a zero length marks a row without an instruction.
    function automatic tbl_entry_t decode_entry(input tbl_addr_t a);
        tbl_entry_t e;
        e.len  = '0;
        e.uidx = '0;
        unique case (classify(a.opc))
            CLS_SHORT: e.len = a.wide ? 2'd0 : 2'd1;
            CLS_MID:   e.len = a.wide ? 2'd3 : 2'd2;
            CLS_LONG:  e.len = a.wide ? 2'd0 : 2'd3;
            default:   e.len = 2'd0;
        endcase
        if (e.len != '0) e.uidx = {a.wide, 1'b0, a.opc};
        return e;
    endfunction

endpackage

// File: rtl/bld_opcode_table.sv
module bld_opcode_table
    import bld_pkg::*;
(
    input  tbl_addr_t  addr,
    output tbl_entry_t entry
);
    tbl_entry_t per_mode [2];

    for (genvar w = 0; w < 2; w++) begin : g_mode
        tbl_addr_t a_w;
        assign a_w.wide = 1'(w);
        assign a_w.opc  = addr.opc;
        assign per_mode[w] = decode_entry(a_w);
    end

    assign entry = per_mode[addr.wide];
endmodule

// File: rtl/bld_stream_parser.sv
module bld_stream_parser
    import bld_pkg::*;
#(
    parameter logic [BYTE_W-1:0] WIDE_CODE = 8'hC4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  logic [BYTE_W-1:0] byte_in,
    output tbl_addr_t         tbl_addr,
    input  tbl_entry_t        tbl_entry,
    output logic              load_idx,
    output logic [IDX_W-1:0]  load_uidx,
    output opnd_t             opnd_q,
    output logic              illegal_q
);
    logic [LEN_W-1:0] remain_q;
    logic [POS_W-1:0] pos_q;
    logic             wide_q;

    logic opc_slot;
    logic is_prefix;
    logic no_entry;

    assign opc_slot  = (remain_q == '0);
    assign is_prefix = opc_slot && !wide_q && (byte_in == WIDE_CODE);
    assign tbl_addr  = '{wide: wide_q, opc: byte_in};
    assign no_entry  = (tbl_entry.len == '0);

    assign load_idx  = accept && opc_slot && !is_prefix && !no_entry;
    assign load_uidx = tbl_entry.uidx;

    always_ff @(posedge clk) begin
        if (rst) begin
            remain_q  <= '0;
            pos_q     <= '0;
            wide_q    <= 1'b0;
            opnd_q    <= '0;
            illegal_q <= 1'b0;
        end else begin
            opnd_q.vld <= 1'b0;
            illegal_q  <= 1'b0;
            if (accept) begin
                if (opc_slot) begin
                    if (is_prefix) begin
                        wide_q <= 1'b1;
                    end else begin
                        wide_q <= 1'b0;
                        if (no_entry) begin
                            illegal_q <= 1'b1;
                        end else begin
                            remain_q <= tbl_entry.len - 1'b1;
                            pos_q    <= POS_W'(1);
                        end
                    end
                end else begin
                    opnd_q.vld  <= 1'b1;
                    opnd_q.data <= byte_in;
                    opnd_q.pos  <= pos_q;
                    pos_q       <= pos_q + 1'b1;
                    remain_q    <= remain_q - 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/bld_index_slot.sv
module bld_index_slot
    import bld_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [IDX_W-1:0] uidx_in,
    input  logic             take,
    output logic             full,
    output logic [IDX_W-1:0] uidx_q,
    output logic             can_accept
);
    assign can_accept = !full || take;

    always_ff @(posedge clk) begin
        if (rst) begin
            full   <= 1'b0;
            uidx_q <= '0;
        end else if (load) begin
            full   <= 1'b1;
            uidx_q <= uidx_in;
        end else if (take) begin
            full   <= 1'b0;
        end
    end
endmodule

// File: rtl/bytecode_len_decoder.sv
module bytecode_len_decoder
    import bld_pkg::*;
#(
    parameter logic [BYTE_W-1:0] WIDE_CODE = 8'hC4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_data,
    output logic              in_ready,
    output logic              out_valid,
    output logic [IDX_W-1:0]  out_uidx,
    input  logic              out_ready,
    output logic              opnd_valid,
    output logic [BYTE_W-1:0] opnd_data,
    output logic [POS_W-1:0]  opnd_pos,
    output logic              illegal
);
    tbl_addr_t        tbl_addr;
    tbl_entry_t       tbl_entry;
    logic             load_idx;
    logic [IDX_W-1:0] load_uidx;
    opnd_t            opnd_q;
    logic             accept;

    assign accept = in_valid && in_ready;

    bld_opcode_table u_table (
        .addr  (tbl_addr),
        .entry (tbl_entry)
    );

    bld_stream_parser #(.WIDE_CODE(WIDE_CODE)) u_parser (
        .clk       (clk),
        .rst       (rst),
        .accept    (accept),
        .byte_in   (in_data),
        .tbl_addr  (tbl_addr),
        .tbl_entry (tbl_entry),
        .load_idx  (load_idx),
        .load_uidx (load_uidx),
        .opnd_q    (opnd_q),
        .illegal_q (illegal)
    );

    bld_index_slot u_slot (
        .clk        (clk),
        .rst        (rst),
        .load       (load_idx),
        .uidx_in    (load_uidx),
        .take       (out_ready),
        .full       (out_valid),
        .uidx_q     (out_uidx),
        .can_accept (in_ready)
    );

    assign opnd_valid = opnd_q.vld;
    assign opnd_data  = opnd_q.data;
    assign opnd_pos   = opnd_q.pos;
endmodule

// File: rtl/bytecode_len_decoder_chk.sv
module bytecode_len_decoder_chk
    import bld_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic             in_ready,
    input logic             out_valid,
    input logic [IDX_W-1:0] out_uidx,
    input logic             out_ready,
    input logic             opnd_valid,
    input logic [POS_W-1:0] opnd_pos,
    input logic             illegal
);
    AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!out_valid && !opnd_valid && !illegal)); // R1

    AST_WIDE_SHAPE: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_uidx[IDX_W-1]) |-> (out_uidx[IDX_W-2 -: 3] == 3'b001)); // R4

    AST_ILLEGAL_SOLO: assert property (@(posedge clk) disable iff (rst)
        illegal |-> !opnd_valid); // R6

    AST_ILLEGAL_CAUSE: assert property (@(posedge clk) disable iff (rst)
        illegal |-> $past(in_valid && in_ready)); // R6

    AST_OPND_CAUSE: assert property (@(posedge clk) disable iff (rst)
        opnd_valid |-> $past(in_valid && in_ready)); // R7

    AST_OPND_POS_RANGE: assert property (@(posedge clk) disable iff (rst)
        opnd_valid |-> (opnd_pos == 2'd1 || opnd_pos == 2'd2)); // R7

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_uidx))); // R8

    AST_STALL_WHEN_FULL: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |-> !in_ready); // R8

    AST_READY_WHEN_FREE: assert property (@(posedge clk) disable iff (rst)
        (!out_valid || out_ready) |-> in_ready); // R8
endmodule

bind bytecode_len_decoder bytecode_len_decoder_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .out_valid  (out_valid),
    .out_uidx   (out_uidx),
    .out_ready  (out_ready),
    .opnd_valid (opnd_valid),
    .opnd_pos   (opnd_pos),
    .illegal    (illegal)
);

// File: tb/bytecode_len_decoder_tb_top.sv
module bytecode_len_decoder_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       in_ready;
    logic       out_valid;
    logic [9:0] out_uidx;
    logic       out_ready = 1'b0;
    logic       opnd_valid;
    logic [7:0] opnd_data;
    logic [1:0] opnd_pos;
    logic       illegal;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // reference model state
    int       m_cnt = 0;
    int       m_pos = 0;
    bit       m_wide = 1'b0;
    bit       m_outv = 1'b0;
    bit [9:0] m_uidx = '0;

    always #2 clk = ~clk;

    bytecode_len_decoder dut_i (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
        .out_valid(out_valid), .out_uidx(out_uidx), .out_ready(out_ready),
        .opnd_valid(opnd_valid), .opnd_data(opnd_data), .opnd_pos(opnd_pos),
        .illegal(illegal)
    );

    function automatic int ref_len(bit wide, bit [7:0] opc);
        case (opc[7:6])
            2'b00: return wide ? 0 : 1;
            2'b01: return wide ? 3 : 2;
            2'b10: return wide ? 0 : 3;
            default: return 0;
        endcase
    endfunction

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Called at a negedge: drive, model one edge, check at next negedge.
    task automatic step(bit v, bit [7:0] d, bit r);
        bit acc, nx_outv, nx_ill, nx_opv, ctx_wide;
        bit [9:0] nx_uidx;
        bit [7:0] nx_opd;
        int nx_pos, len;
        in_valid = v; in_data = d; out_ready = r;
        #1;
        chk("R8 in_ready", int'(in_ready), int'(!m_outv || r));
        acc = v && (!m_outv || r);
        nx_outv = m_outv && !r; nx_uidx = m_uidx;
        nx_ill = 0; nx_opv = 0; nx_opd = 0; nx_pos = 0; ctx_wide = m_wide;
        if (acc) begin
            if (m_cnt == 0) begin
                if (!m_wide && d == 8'hC4) m_wide = 1;
                else begin
                    len = ref_len(m_wide, d);
                    if (len == 0) nx_ill = 1;
                    else begin
                        nx_outv = 1; nx_uidx = {m_wide, 1'b0, d};
                        m_cnt = len - 1; m_pos = 1;
                    end
                    m_wide = 0;
                end
            end else begin
                nx_opv = 1; nx_opd = d; nx_pos = m_pos;
                m_pos++; m_cnt--;
            end
        end
        @(negedge clk);
        chk("R3 out_valid", int'(out_valid), int'(nx_outv));
        if (nx_outv) chk(nx_uidx[9] ? "R4 wide out_uidx" : "R3 out_uidx", int'(out_uidx), int'(nx_uidx));
        chk(ctx_wide ? "R5 illegal" : "R6 illegal", int'(illegal), int'(nx_ill));
        chk("R2 opnd_valid", int'(opnd_valid), int'(nx_opv));
        if (nx_opv) begin
            chk("R7 opnd_data", int'(opnd_data), int'(nx_opd));
            chk("R7 opnd_pos", int'(opnd_pos), nx_pos);
        end
        m_outv = nx_outv; m_uidx = nx_uidx;
    endtask

    task automatic feed(bit [7:0] d);
        step(1'b1, d, 1'b1);
    endtask

    task automatic do_reset();
        rst = 1'b1; in_valid = 0; out_ready = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        m_cnt = 0; m_pos = 0; m_wide = 0; m_outv = 0; m_uidx = '0;
    endtask

    initial begin
        bit [7:0] b;
        int sel;
        void'($urandom(32'h5EED_1234));
        @(negedge clk);
        do_reset();
        // R1: reset state
        chk("R1 out_valid", int'(out_valid), 0);
        chk("R1 opnd_valid", int'(opnd_valid), 0);
        chk("R1 illegal", int'(illegal), 0);
        // R2/R3: lengths 1, 2, 3
        feed(8'h10);
        feed(8'h45); feed(8'hAA);
        feed(8'h90); feed(8'h01); feed(8'h02);
        feed(8'h3F);
        // R4: wide prefix then two-byte form
        feed(8'hC4); feed(8'h50); feed(8'h11); feed(8'h22); feed(8'h07);
        // R5: wide with short opcode, then double prefix
        feed(8'hC4); feed(8'h10); feed(8'h20);
        feed(8'hC4); feed(8'hC4); feed(8'h41); feed(8'h33);
        // R6: illegal normal opcodes consumed as one byte
        feed(8'hF0); feed(8'h05); feed(8'hFF); feed(8'hFF); feed(8'h80); feed(8'hFF); feed(8'hEE);
        // R8: backpressure hold
        step(1'b1, 8'h12, 1'b0);
        step(1'b1, 8'h13, 1'b0);
        step(1'b1, 8'h14, 1'b0);
        step(1'b0, 8'h00, 1'b1);
        // R1: reset mid-instruction, next byte must be opcode
        feed(8'h90); feed(8'h55);
        do_reset();
        feed(8'h20);
        // R1: reset while wide armed
        feed(8'hC4);
        do_reset();
        feed(8'h60); feed(8'h61);
        // random stream
        for (int i = 0; i < 4000; i++) begin
            sel = $urandom_range(0, 9);
            b = 8'($urandom);
            if (sel == 0) b = 8'hC4;
            step(($urandom_range(0, 3) != 0), b, ($urandom_range(0, 2) != 0));
        end
        step(1'b0, 8'h00, 1'b1);
        step(1'b0, 8'h00, 1'b1);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule